// File: doc/BRIEF.md
# Latched Current-Mode PWM Cycle Gate

This block produces the single gate-drive bit of a fixed-frequency current-mode converter. It runs from a system clock and takes digital flags in place of the analog parts: an oscillator dead-time pulse that marks the boundary between switching periods, a flag that is high once the oscillator ramp has passed the programmed duty threshold, and a flag from the peak-current comparator. The block turns the drive on at the start of each period. It turns the drive off at whichever comes first: the duty limit, or a current trip that arrives after the leading-edge blanking window.

The pulse logic is fully latched. Once the drive has ended within a period, nothing can turn it on again until the next dead-time pulse. A half-duty mode adds a toggle stage, so that drive is allowed only in every other period. This halves the switching frequency and keeps the duty below about 50%. When the half-duty mode is off, the drive may last for the whole period up to the next dead-time pulse. A global enable stops the drive at once and puts the toggle stage back to its starting phase.

Top module: `pwm_cycle_gate`

## Requirements
- R1: While `oscPulse` is high, `gateOut` is 0, combinationally and on every clock in between. No drive spans the dead time.
- R2: After reset `gateOut` is 0. In a period that is allowed to drive, `gateOut` goes to 1 on the first clock edge at which `oscPulse` is sampled low after having been high, provided `enable` is 1 and `dutyReached` is 0 at that edge.
- R3: When `dutyReached` is sampled 1 while the drive is on, `gateOut` is 0 after that clock edge.
- R4: `curTrip` has no effect on the `BLANK_CYC` clock edges that follow the turn-on edge. A trip seen during that window is dropped, not held over. A trip sampled on any later edge of the period clears `gateOut` at that edge.
- R5: Once the drive has ended in a period, `gateOut` stays 0 until the next `oscPulse`, even after `dutyReached` and `curTrip` have returned to 0.
- R6: With `halfMode` at 1, a phase bit toggles on each rising edge of `oscPulse`, and drive is allowed only when the bit is 1. The bit is held at 0 while `halfMode` is 0, so the first period after half mode is selected drives, the next is skipped, and so on. With `halfMode` at 0, every period drives.
- R7: If `dutyReached` is 1 at the edge where the period would start, there is no pulse in that period (0% duty).
- R8: When `enable` is 0, `gateOut` is 0 at once. On the next edge the pulse latch and its arming are cleared and the phase bit is reset to 0. After `enable` returns, drive resumes only from the next `oscPulse`.
- R9: With no duty limit and no trip, the drive stays on from turn-on until `oscPulse` next rises, giving nearly 100% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; 0 forces the drive off |
| halfMode | input | 1 | 1 selects alternate-period drive (half frequency, about 50% duty cap) |
| oscPulse | input | 1 | Oscillator dead-time pulse; its rising edge marks a new period |
| dutyReached | input | 1 | Ramp has passed the programmed duty threshold |
| curTrip | input | 1 | Peak-current comparator trip |
| gateOut | output | 1 | Gate-drive bit |

## Verification
The assertions take three things for granted about the inputs. All inputs are synchronous to `clk`. Each `oscPulse` lasts at least one clock. `halfMode` does not change while a period is driving. The bench drives every input on the falling clock edge. It holds `oscPulse` high for two clocks per period and changes `halfMode` only in the same cycle that `oscPulse` rises. It sweeps single-cycle duty-limit pulses and single-cycle trip pulses across every clock position of a 12-clock period, with a blanking window of 4 clocks. The expected drive level at each clock is computed from the positions of those pulses and from a model of the phase bit.

// File: rtl/pwm_cycle_pkg.sv
package pwm_cycle_pkg;
  // Strobes sent from the pulse-latch control to the timing datapath.
  typedef struct packed {
    logic loadBlank;   // drive turning on: restart blanking window
    logic stepPhase;   // new period in half mode: toggle phase
    logic clearPhase;  // half mode off or disabled: phase to 0
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_cycle_pkg::*;
#(
  parameter int BLANK_CYC = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  pwmStrobe_t strobe,
  output logic       blankOver,
  output logic       phase
);
  localparam int CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  logic [CW-1:0] blankCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (strobe.loadBlank) begin
      blankCnt <= LOAD;
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - CW'(1);
    end
  end

  assign blankOver = (blankCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 1'b0;
    end else if (strobe.clearPhase) begin
      phase <= 1'b0;
    end else if (strobe.stepPhase) begin
      phase <= ~phase;
    end
  end

  // R4: the window counter never leaves its programmed range
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    blankCnt <= LOAD);
endmodule

// File: rtl/pwm_latch_ctl.sv
module pwm_latch_ctl
  import pwm_cycle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       halfMode,
  input  logic       oscPulse,
  input  logic       dutyReached,
  input  logic       curTrip,
  input  logic       blankOver,
  input  logic       phase,
  output pwmStrobe_t strobe,
  output logic       gateQ
);
  logic oscPrev;
  logic armed;
  logic cycleAllowed;
  logic startNow;
  logic stopNow;

  always_comb begin
    cycleAllowed      = !halfMode || phase;
    startNow          = enable && armed && !oscPulse && cycleAllowed && !dutyReached;
    stopNow           = gateQ && (dutyReached || (curTrip && blankOver));
    strobe.loadBlank  = startNow;
    strobe.stepPhase  = enable && halfMode && oscPulse && !oscPrev;
    strobe.clearPhase = !enable || !halfMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscPrev <= 1'b0;
      armed   <= 1'b0;
      gateQ   <= 1'b0;
    end else begin
      oscPrev <= oscPulse;
      if (!enable) begin
        armed <= 1'b0;
        gateQ <= 1'b0;
      end else if (oscPulse) begin
        armed <= 1'b1;
        gateQ <= 1'b0;
      end else begin
        armed <= 1'b0;
        if (startNow) begin
          gateQ <= 1'b1;
        end else if (stopNow) begin
          gateQ <= 1'b0;
        end
      end
    end
  end

  // R1: a dead-time pulse always leaves the latch off
  a_r1_dead_low: assert property (@(posedge clk) disable iff (!rstN)
    oscPulse |=> !gateQ);

  // R5: with no fresh dead-time pulse, an off latch stays off
  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!oscPulse && !oscPrev && !gateQ) |=> !gateQ);

  // R4: a trip inside the blanking window does not end the pulse
  a_r4_blank_mask: assert property (@(posedge clk) disable iff (!rstN)
    (gateQ && !blankOver && !dutyReached && enable && !oscPulse) |=> gateQ);

  // R7: a duty limit present at period start blocks turn-on
  a_r7_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
    (!gateQ && dutyReached) |=> !gateQ);

  // R6: a skipped half-mode period never drives
  a_r6_skip_phase: assert property (@(posedge clk) disable iff (!rstN)
    (!gateQ && halfMode && !phase && !oscPulse) |=> !gateQ);
endmodule

// File: rtl/pwm_cycle_gate.sv
module pwm_cycle_gate
  import pwm_cycle_pkg::*;
#(
  parameter int BLANK_CYC = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic halfMode,
  input  logic oscPulse,
  input  logic dutyReached,
  input  logic curTrip,
  output logic gateOut
);
  pwmStrobe_t strobe;
  logic       blankOver;
  logic       phase;
  logic       gateQ;

  pwm_latch_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .halfMode    (halfMode),
    .oscPulse    (oscPulse),
    .dutyReached (dutyReached),
    .curTrip     (curTrip),
    .blankOver   (blankOver),
    .phase       (phase),
    .strobe      (strobe),
    .gateQ       (gateQ)
  );

  pwm_timer_dp #(.BLANK_CYC(BLANK_CYC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .blankOver (blankOver),
    .phase     (phase)
  );

  assign gateOut = gateQ && enable && !oscPulse;

  // R8: a disabled cycle leaves latch and phase cleared
  a_r8_enable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!gateQ && !phase));
endmodule

// File: tb/pwm_cycle_gate_tb.sv
module pwm_cycle_gate_tb;
  localparam int B = 4;
  localparam int L = 12;
  localparam int INF = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic halfMode = 1'b0;
  logic oscPulse = 1'b0;
  logic dutyReached = 1'b0;
  logic curTrip = 1'b0;
  logic gateOut;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;
  bit expPhase = 0;

  always #2 clk = ~clk;

  pwm_cycle_gate #(.BLANK_CYC(B)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .halfMode(halfMode),
    .oscPulse(oscPulse), .dutyReached(dutyReached), .curTrip(curTrip),
    .gateOut(gateOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: gateOut=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One period: two dead clocks, then L clocks low. d/t are the low-phase
  // indices of single-clock duty/trip pulses (-1 = none); dropAt disables.
  task automatic runCycle(input int d, input int t, input bit half,
                          input string tag, input int dropAt = -1);
    bit allowed;
    int dEnd;
    int tEnd;
    halfMode    = half;
    oscPulse    = 1'b1;
    dutyReached = 1'b0;
    curTrip     = 1'b0;
    #1 check("R1", gateOut, 1'b0);
    if (!enable || !half) expPhase = 0;
    else expPhase = !expPhase;
    allowed = enable && (!half || expPhase);
    dEnd = (d < 0) ? INF : d;
    tEnd = (t > B) ? t : INF;
    @(negedge clk);
    check("R1", gateOut, 1'b0);
    for (int j = 0; j <= L; j++) begin
      @(negedge clk);
      if (j > 0) begin
        logic e;
        e = allowed && (j - 1 < dEnd) && (j - 1 < tEnd);
        check((j == 1) ? ((d == 0) ? "R7" : "R2") : tag, gateOut, e);
      end
      if (j < L) begin
        oscPulse    = 1'b0;
        dutyReached = (j == d);
        curTrip     = (j == t);
        if (j == dropAt) begin
          enable = 1'b0;
          #1 check("R8", gateOut, 1'b0);
          allowed  = 0;
          expPhase = 0;
        end
      end
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", gateOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", gateOut, 1'b0);
    enable = 1'b1;
    @(negedge clk);

    runCycle(-1, -1, 0, "R9");
    runCycle(-1, -1, 0, "R9");
    for (int d = 1; d < L; d++) runCycle(d, -1, 0, "R3");
    runCycle(0, -1, 0, "R7");
    runCycle(4, -1, 0, "R5");
    for (int t = 0; t < L; t++) runCycle(-1, t, 0, "R4");
    runCycle(3, 8, 0, "R3");
    runCycle(9, 6, 0, "R4");
    runCycle(7, 2, 0, "R4");

    for (int k = 0; k < 6; k++) runCycle(-1, -1, 1, "R6");
    runCycle(5, -1, 1, "R6");
    runCycle(-1, -1, 1, "R6");
    runCycle(-1, -1, 0, "R6");
    runCycle(-1, -1, 0, "R6");

    runCycle(-1, -1, 1, "R6");
    runCycle(-1, -1, 1, "R6");
    runCycle(-1, -1, 1, "R8", 3);
    runCycle(-1, -1, 1, "R8");
    enable = 1'b1;
    runCycle(-1, -1, 1, "R8");
    runCycle(-1, -1, 1, "R8");
    runCycle(-1, -1, 1, "R8");

    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R8", gateOut, 1'b0);
    runCycle(-1, -1, 0, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule